// File: doc/BRIEF.md
# Protected Register Write Guard

This block sits on a simple byte-wide peripheral register bus and guards a small bank of control registers against stray writes. A protected register only takes a write when the write event just before it on the bus went to a dedicated unlock command register. Software first writes any value to the command register and then makes the protected write. Reads in between do not disturb the sequence. Any write that breaks the sequence raises a sticky error flag in a status register. Software can read that flag and clear it by writing 0.

The bus carries an address, a write strobe, a read strobe, write data and a read-modify-write qualifier. The read phase of a read-modify-write access (read strobe with the qualifier high) counts as a write for sequencing. A small bank of ordinary registers shares the bus and can be written at any time. Address map, with 4-bit addresses: command register at 0, status register at 1, protected registers at 4 to 7, ordinary registers at 8 and 9. All other addresses are unmapped.

Top module: `prot_write_guard`

## Requirements
- R1: A write to a protected register (address 4 to 7) updates it only when the previous write event went to the command register (address 0) and was accepted as an unlock. Otherwise the write is discarded and the register keeps its value.
- R2: A plain read (read strobe with the read-modify-write qualifier low) between the unlock and the protected write neither cancels the unlock nor sets the error flag.
- R3: A protected-register write made while not unlocked sets the error flag (status bit 0) to 1 on the next clock edge.
- R4: While unlocked, the next write event sets the error flag and ends the unlock if it is a write to the status register, an ordinary register or an unmapped address, or a read with the read-modify-write qualifier high to any address.
- R5: A command-register write made while already unlocked sets the error flag and leaves the guard locked, so a following protected write is discarded.
- R6: A write to the status register loads wdata bit 0 into the error flag. When that write directly follows a command-register write, the written value takes precedence over the violation, so writing 0 leaves the flag at 0.
- R7: Once set, the error flag stays 1 through reads and other writes until the status register is written with bit 0 equal to 0, or until reset.
- R8: Synchronous active-high reset clears the error flag, the unlock state and all registers. After reset the status register reads 00h, and bits 7:1 of the status register always read 0.
- R9: With the read strobe high, rdata shows the addressed register in the same cycle. The command register and unmapped addresses read 00h. With the read strobe low, rdata is 00h.
- R10: Ordinary registers (addresses 8 and 9) take every write, whether the guard is locked or unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rmw | input | 1 | Read-modify-write qualifier |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |

## Verification
The hardest case to reach is the one where a clear and a set land in the same cycle. It needs the flag already set, then an unlock, then a status write of 0 in the very next write slot, with no write event in between. The bench builds this on purpose: it first raises the flag with an unguarded protected write, then issues the command write, then writes the status register. It repeats the pattern with plain reads inserted to show that reads do not use up the slot. Read-modify-write read phases are injected directly after an unlock so that they act as violations. A random mix of all access kinds is then compared on every cycle against a behavioural model.

// File: rtl/pwg_pkg.sv
package pwg_pkg;

    typedef enum logic [2:0] {
        ACC_UNMAP,
        ACC_CMD,
        ACC_STAT,
        ACC_PROT,
        ACC_ORD
    } acc_kind_e;

    typedef struct packed {
        logic      wr;      // real write strobe
        logic      rmw_rd;  // read phase of a read-modify-write
        logic      rd;      // read strobe
        acc_kind_e kind;    // decoded target
    } bus_evt_t;

    function automatic acc_kind_e classify(input int a, input int cmd_a, input int stat_a,
                                           input int prot_base, input int nprot,
                                           input int ord_base, input int nord);
        if (a == cmd_a)                                   return ACC_CMD;
        if (a == stat_a)                                  return ACC_STAT;
        if (a >= prot_base && a < prot_base + nprot)      return ACC_PROT;
        if (a >= ord_base && a < ord_base + nord)         return ACC_ORD;
        return ACC_UNMAP;
    endfunction

endpackage

// File: rtl/pwg_decode.sv
module pwg_decode
    import pwg_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CMD_ADDR  = 0,
    parameter int STAT_ADDR = 1,
    parameter int PROT_BASE = 4,
    parameter int NPROT     = 4,
    parameter int ORD_BASE  = 8,
    parameter int NORD      = 2,
    parameter int OFF_W     = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              rmw,
    output bus_evt_t          evt,
    output logic [OFF_W-1:0]  prot_off,
    output logic [OFF_W-1:0]  ord_off
);
    logic [ADDR_W-1:0] rel_p;
    logic [ADDR_W-1:0] rel_o;

    always_comb begin
        evt.wr     = wr_en;
        evt.rd     = rd_en;
        evt.rmw_rd = rd_en & rmw & ~wr_en;
        evt.kind   = classify(int'(addr), CMD_ADDR, STAT_ADDR, PROT_BASE, NPROT, ORD_BASE, NORD);
        rel_p      = addr - ADDR_W'(PROT_BASE);
        rel_o      = addr - ADDR_W'(ORD_BASE);
        prot_off   = rel_p[OFF_W-1:0];
        ord_off    = rel_o[OFF_W-1:0];
    end
endmodule

// File: rtl/pwg_seq_tracker.sv
module pwg_seq_tracker
    import pwg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_evt_t evt,
    input  logic     wbit0,
    output logic     unlocked,
    output logic     err_flag,
    output logic     prot_commit
);
    logic seq_evt, cmd_wr, prot_wr, stat_wr, viol;
    logic unl_n, err_n;

    always_comb begin
        seq_evt     = evt.wr | evt.rmw_rd;
        cmd_wr      = evt.wr && evt.kind == ACC_CMD;
        prot_wr     = evt.wr && evt.kind == ACC_PROT;
        stat_wr     = evt.wr && evt.kind == ACC_STAT;
        prot_commit = prot_wr && unlocked;
        viol        = seq_evt && ((prot_wr && !unlocked) || (unlocked && !prot_wr));
        unl_n       = unlocked;
        err_n       = err_flag;
        if (seq_evt) unl_n = cmd_wr && !unlocked;
        if (viol)    err_n = 1'b1;
        if (stat_wr) err_n = wbit0;   // explicit write wins over a same-cycle violation
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            unlocked <= 1'b0;
            err_flag <= 1'b0;
        end else begin
            unlocked <= unl_n;
            err_flag <= err_n;
        end
    end

    // R2: a plain read leaves the unlock state untouched
    a_r2_read_keeps_unlock: assert property (@(posedge clk) disable iff (rst)
        (evt.rd && !evt.wr && !evt.rmw_rd) |=> $stable(unlocked));
    // R3: unguarded protected write raises the flag
    a_r3_unguarded_sets_err: assert property (@(posedge clk) disable iff (rst)
        (evt.wr && evt.kind == ACC_PROT && !unlocked) |=> err_flag);
    // R5: double command write is a violation and does not re-arm
    a_r5_double_cmd: assert property (@(posedge clk) disable iff (rst)
        (evt.wr && evt.kind == ACC_CMD && unlocked) |=> (err_flag && !unlocked));
    // R6: status write of 0 always clears, even right after an unlock
    a_r6_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (evt.wr && evt.kind == ACC_STAT && !wbit0) |=> !err_flag);
    // R7: flag is sticky without a status write
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !(evt.wr && evt.kind == ACC_STAT)) |=> err_flag);
endmodule

// File: rtl/pwg_reg_bank.sv
module pwg_reg_bank #(
    parameter int DW    = 8,
    parameter int NPROT = 4,
    parameter int NORD  = 2,
    parameter int OFF_W = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       prot_we,
    input  logic                       ord_we,
    input  logic [OFF_W-1:0]           prot_off,
    input  logic [OFF_W-1:0]           ord_off,
    input  logic [DW-1:0]              wdata,
    output logic [NPROT-1:0][DW-1:0]   prot_q,
    output logic [NORD-1:0][DW-1:0]    ord_q
);
    for (genvar i = 0; i < NPROT; i++) begin : g_prot
        always_ff @(posedge clk) begin
            if (rst)                                  prot_q[i] <= '0;
            else if (prot_we && prot_off == OFF_W'(i)) prot_q[i] <= wdata;
        end
    end

    for (genvar j = 0; j < NORD; j++) begin : g_ord
        always_ff @(posedge clk) begin
            if (rst)                                 ord_q[j] <= '0;
            else if (ord_we && ord_off == OFF_W'(j)) ord_q[j] <= wdata;
        end
    end
endmodule

// File: rtl/prot_write_guard.sv
module prot_write_guard
    import pwg_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DW        = 8,
    parameter int CMD_ADDR  = 0,
    parameter int STAT_ADDR = 1,
    parameter int PROT_BASE = 4,
    parameter int NPROT     = 4,
    parameter int ORD_BASE  = 8,
    parameter int NORD      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              rmw,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata
);
    localparam int NMAX  = (NPROT > NORD) ? NPROT : NORD;
    localparam int OFF_W = (NMAX > 1) ? $clog2(NMAX) : 1;

    bus_evt_t                  evt;
    logic [OFF_W-1:0]          prot_off, ord_off;
    logic                      unlocked, err_flag, prot_commit;
    logic [NPROT-1:0][DW-1:0]  prot_q;
    logic [NORD-1:0][DW-1:0]   ord_q;

    pwg_decode #(
        .ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR), .STAT_ADDR(STAT_ADDR),
        .PROT_BASE(PROT_BASE), .NPROT(NPROT), .ORD_BASE(ORD_BASE),
        .NORD(NORD), .OFF_W(OFF_W)
    ) u_dec (
        .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .rmw(rmw),
        .evt(evt), .prot_off(prot_off), .ord_off(ord_off)
    );

    pwg_seq_tracker u_seq (
        .clk(clk), .rst(rst), .evt(evt), .wbit0(wdata[0]),
        .unlocked(unlocked), .err_flag(err_flag), .prot_commit(prot_commit)
    );

    pwg_reg_bank #(.DW(DW), .NPROT(NPROT), .NORD(NORD), .OFF_W(OFF_W)) u_bank (
        .clk(clk), .rst(rst),
        .prot_we(prot_commit),
        .ord_we(evt.wr && evt.kind == ACC_ORD),
        .prot_off(prot_off), .ord_off(ord_off), .wdata(wdata),
        .prot_q(prot_q), .ord_q(ord_q)
    );

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (evt.kind)
                ACC_STAT: rdata = {{(DW-1){1'b0}}, err_flag};
                ACC_PROT: rdata = prot_q[prot_off];
                ACC_ORD:  rdata = ord_q[ord_off];
                default:  rdata = '0;
            endcase
        end
    end

    // R1: a locked protected write leaves the protected bank unchanged
    a_r1_locked_write_dropped: assert property (@(posedge clk) disable iff (rst)
        (wr_en && evt.kind == ACC_PROT && !unlocked) |=> $stable(prot_q));
    // R4: a non-protected write event while unlocked flags an error
    a_r4_other_write_flags: assert property (@(posedge clk) disable iff (rst)
        (unlocked && ((wr_en && evt.kind inside {ACC_ORD, ACC_UNMAP}) || evt.rmw_rd)) |=> (err_flag && !unlocked));
    // R9: no read strobe, no read data
    a_r9_idle_rdata: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> rdata == '0);
endmodule

// File: tb/prot_write_guard_tb.sv
module prot_write_guard_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] addr;
    logic       wr_en, rd_en, rmw;
    logic [7:0] wdata;
    logic [7:0] rdata;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // behavioural reference state
    int m_unl, m_err;
    int m_prot[4];
    int m_ord[2];

    always #(CLK_PERIOD/2) clk = ~clk;

    prot_write_guard u_dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .rmw(rmw), .wdata(wdata), .rdata(rdata)
    );

    function automatic int expect_rd(input int a, input bit r);
        if (!r) return 0;
        if (a == 1) return m_err;
        if (a >= 4 && a <= 7) return m_prot[a-4];
        if (a == 8 || a == 9) return m_ord[a-8];
        return 0;
    endfunction

    task automatic model_step(input bit rs, input int a, input bit w, input bit r,
                              input bit m, input int d);
        bit is_evt, hit_prot;
        if (rs) begin
            m_unl = 0; m_err = 0;
            foreach (m_prot[k]) m_prot[k] = 0;
            foreach (m_ord[k])  m_ord[k] = 0;
            return;
        end
        is_evt   = w || (r && m);
        hit_prot = w && a >= 4 && a <= 7;
        if (!is_evt) return;
        if (hit_prot && m_unl == 1) m_prot[a-4] = d;
        if (w && (a == 8 || a == 9)) m_ord[a-8] = d;
        if ((hit_prot && m_unl == 0) || (m_unl == 1 && !hit_prot)) m_err = 1;
        if (w && a == 1) m_err = d & 1;
        m_unl = (w && a == 0 && m_unl == 0) ? 1 : 0;
    endtask

    // one bus cycle: drive at falling edge, compare, then advance the model
    task automatic cyc(input bit rs, input int a, input bit w, input bit r,
                       input bit m, input int d, input string tag);
        int exp_v;
        @(negedge clk);
        rst = rs; addr = 4'(a); wr_en = w; rd_en = r; rmw = m; wdata = 8'(d);
        #1;
        exp_v = expect_rd(a, r);
        n_vec++;
        if (int'(rdata) != exp_v) begin
            n_bad++;
            $display("FAIL %s addr=%0d actual=%02h expected=%02h", tag, a, rdata, exp_v);
        end
        @(posedge clk);
        model_step(rs, a, w, r, m, d);
    endtask

    task automatic wr(input int a, input int d, input string tag);
        cyc(0, a, 1, 0, 0, d, tag);
    endtask
    task automatic rd(input int a, input string tag);
        cyc(0, a, 0, 1, 0, 0, tag);
    endtask

    initial begin
        rst = 1; addr = 0; wr_en = 0; rd_en = 0; rmw = 0; wdata = 0;
        cyc(1, 0, 0, 0, 0, 0, "R8");
        cyc(1, 0, 0, 0, 0, 0, "R8");
        rd(1, "R8 status after reset");
        for (int i = 4; i < 8; i++) rd(i, "R8 protected after reset");

        // legal sequence
        wr(0, 8'h00, "R1"); wr(4, 8'h5A, "R1"); rd(4, "R1 legal write");
        rd(1, "R1 no error");

        // reads in the middle
        wr(0, 0, "R2"); rd(1, "R2"); rd(8, "R2"); rd(5, "R2");
        wr(5, 8'h33, "R2"); rd(5, "R2 commit after reads"); rd(1, "R2 no error");

        // unguarded protected write
        wr(6, 8'hEE, "R3"); rd(6, "R1 discarded"); rd(1, "R3 flag set");

        // sticky flag
        rd(1, "R7"); wr(9, 8'h11, "R7"); rd(1, "R7 after ord write");
        wr(1, 8'hFE, "R6 write bit0=0"); rd(1, "R6 cleared");
        wr(1, 8'h01, "R6 write bit0=1"); rd(1, "R6 set by write");
        wr(1, 8'h00, "R6"); rd(1, "R6");

        // ordinary write after unlock
        wr(0, 0, "R4"); wr(8, 8'hC3, "R4"); rd(1, "R4 flag"); rd(8, "R10 ord took data");
        wr(7, 8'h77, "R4"); rd(7, "R4 unlock consumed"); wr(1, 0, "R6");

        // read-modify-write read phase after unlock
        wr(0, 0, "R4"); cyc(0, 1, 0, 1, 1, 0, "R4 rmw read"); rd(1, "R4 rmw flag");
        wr(4, 8'h99, "R4"); rd(4, "R4 rmw consumed unlock"); wr(1, 0, "R6");

        // unmapped write after unlock
        wr(0, 0, "R4"); wr(14, 8'h12, "R4"); rd(1, "R4 unmapped flag"); wr(1, 0, "R6");

        // back-to-back command writes
        wr(0, 0, "R5"); wr(0, 0, "R5"); rd(1, "R5 flag");
        wr(6, 8'h66, "R5"); rd(6, "R5 still locked"); wr(1, 0, "R6");

        // precedence: clear right after unlock, flag already set
        wr(4, 1, "R6 set flag"); rd(1, "R6");
        wr(0, 0, "R6"); rd(2, "R6"); wr(1, 8'h00, "R6 precedence"); rd(1, "R6 clear wins");
        wr(0, 0, "R6"); wr(1, 8'h00, "R6 precedence"); rd(1, "R6 clear wins flag0");

        // ordinary writes when locked
        wr(9, 8'hA5, "R10"); rd(9, "R10"); rd(1, "R10 no error");

        // read data rules
        rd(0, "R9 cmd reads 0"); rd(12, "R9 unmapped"); rd(15, "R9 unmapped");
        cyc(0, 4, 0, 0, 0, 0, "R9 no strobe");

        // reset mid-run
        wr(4, 2, "R8 prep"); cyc(1, 0, 0, 0, 0, 0, "R8");
        rd(1, "R8 cleared"); rd(4, "R8"); rd(8, "R8");
        wr(5, 8'h44, "R8 unlock cleared"); rd(5, "R8"); wr(1, 0, "R8");

        // random mix
        for (int i = 0; i < 600; i++) begin
            int a, kind;
            a = int'($urandom_range(0, 15));
            if ($urandom_range(0, 3) == 0) a = 0;
            kind = int'($urandom_range(0, 9));
            if (kind < 4)       cyc(0, a, 1, 0, 0, int'($urandom_range(0, 255)), "R1 mix");
            else if (kind < 8)  cyc(0, a, 0, 1, 0, 0, "R9 mix");
            else if (kind == 8) cyc(0, a, 0, 1, 1, 0, "R4 mix");
            else                cyc(0, a, 0, 0, 0, 0, "R9 mix idle");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule